// File: doc/BRIEF.md
# Graphic LCD Controller Host Bus Port

This block sits between an 8-bit microcontroller bus and the core of a dot-matrix LCD controller. The host presents a byte on a shared bidirectional bus together with a data/command select, a read/write select and a chip enable, then pulses a strobe. The strobe rests low and a transfer is taken on its falling edge. All host pins are asynchronous to the controller clock. They pass through a multi-stage synchroniser before the falling edge is detected in the clock domain.

A data write goes to the display memory write port at the current address. A command write is presented to a downstream command decoder as a byte with a one-cycle valid pulse. While the host reads with the strobe high, the port drives the bus with display memory contents, or with a status byte when the command side is selected. The memory address is a column (0 to 119) and a page (0 to 4). It advances after every data transfer, in either direction.

Top module: `lcd_host_port`

## Requirements
- R1: A strobe fall with enable=1, read/write select=0 and data/command select=1 gives exactly one cycle of `ram_we`, two clock edges after the fall reaches the pins. `ram_wdata` carries the bus byte and `ram_addr` carries the address in force before the transfer.
- R2: A strobe fall with enable=1, read/write select=0 and data/command select=0 gives exactly one cycle of `cmd_valid` three edges after the fall, with `cmd_byte` equal to the bus byte. No `ram_we` is produced.
- R3: A strobe fall while enable is low is ignored. There is no `ram_we`, no `cmd_valid` and no address change.
- R4: The port drives `bus_io` only while reset is released, enable is high, read/write select is high and strobe is high. At all other times the bus is released.
- R5: During a data read (enable=1, read/write select=1, data/command select=1, strobe high), `bus_io` equals `ram_rdata` at the current address. The address advances once after the strobe falls.
- R6: During a status read (data/command select=0), `bus_io` carries the current page number in its low bits, with zeros above.
- R7: `ram_addr` is {page, column}, with the column in the low 7 bits and the page in the upper 3. The column steps by one per data transfer and wraps from 119 to 0, which advances the page. The page wraps from 4 to 0.
- R8: While the synchronous active-low reset is held, the address returns to page 0, column 0, both pulses stay low and the bus is released.
- R9: Command writes and status reads leave the address unchanged.
- R10: A rising strobe, and a strobe held high, start no write and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Host chip enable; gates all transfers |
| strobe | input | 1 | Transfer strobe, idle low, taken on its falling edge |
| rw_sel | input | 1 | 1 = host reads, 0 = host writes |
| dc_sel | input | 1 | 1 = display data, 0 = command/status |
| bus_io | inout | 8 | Bidirectional host data bus |
| ram_addr | output | 10 | Display memory address {page, column} |
| ram_wdata | output | 8 | Display memory write byte |
| ram_we | output | 1 | One-cycle display memory write enable |
| ram_rdata | input | 8 | Display memory read byte at `ram_addr` |
| cmd_byte | output | 8 | Latched command byte for the decoder |
| cmd_valid | output | 1 | One-cycle command strobe |

## Verification
Every result is timed from the clock edge after the bench moves the strobe low. The falling edge is seen two edges later, so `ram_we` and the write address are sampled just after the second edge. `cmd_valid` and the advanced address are sampled after the third edge, and the pulses are checked low on the edges before and after. Bus contents are combinational from the pins and memory, so they are read while the strobe is still high. All sampling happens on the falling clock edge, away from the edge that updates the design.

// File: rtl/lcd_host_pkg.sv
// Shared widths and the sampled host-bus record for the host port.
package lcd_host_pkg;
    localparam int DATA_W = 8;

    // One synchronised snapshot of the host pins, in pin-concatenation order.
    typedef struct packed {
        logic              en;
        logic              rd;
        logic              dat;
        logic              stb;
        logic [DATA_W-1:0] val;
    } bus_smp_t;

    localparam int SMP_W = $bits(bus_smp_t);
endpackage

// File: rtl/lcd_host_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes the host keeps the bundle stable around the strobe edges for
// longer than STAGES clock periods, so the bits arrive coherently.
module lcd_host_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin bundle through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lcd_host_route.sv
// Detects the strobe falling edge on synchronised pins and routes the
// transfer: data write pulse, data read advance, or registered command.
// Assumes the inputs come from lcd_host_sync (reset to strobe low).
module lcd_host_route
    import lcd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_smp_t          smp,
    output logic              wr_pulse,
    output logic              rd_adv,
    output logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte
);
    logic stb_d;
    logic act;

    // Remember the previous synchronised strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= smp.stb;
    end

    assign act      = stb_d & ~smp.stb & smp.en;
    assign wr_pulse = act & ~smp.rd & smp.dat;
    assign rd_adv   = act &  smp.rd & smp.dat;
    assign wdata    = smp.val;

    // Register command bytes with a one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= act & ~smp.rd & ~smp.dat;
            if (act & ~smp.rd & ~smp.dat) cmd_byte <= smp.val;
        end
    end
endmodule

// File: rtl/lcd_host_addr.sv
// Column/page address counter for display memory. The column wraps at
// COLS-1 and carries into the page, which wraps at PAGES-1.
module lcd_host_addr #(
    parameter int COLS  = 120,
    parameter int PAGES = 5,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page
);
    // Step the address once per data transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col  <= '0;
            page <= '0;
        end else if (adv) begin
            if (col == COL_W'(COLS-1)) begin
                col  <= '0;
                page <= (page == PAGE_W'(PAGES-1)) ? '0 : page + PAGE_W'(1);
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/lcd_host_port.sv
// Top of the host bus port: synchronises the host pins, routes transfers,
// keeps the display address and drives the bus during host reads.
// Assumes ram_rdata is a combinational read of ram_addr.
module lcd_host_port
    import lcd_host_pkg::*;
#(
    parameter int COLS        = 120,
    parameter int PAGES       = 5,
    parameter int SYNC_STAGES = 2,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int ADDR_W = COL_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              strobe,
    input  logic              rw_sel,
    input  logic              dc_sel,
    inout  wire  [DATA_W-1:0] bus_io,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_valid
);
    logic [SMP_W-1:0]  raw, synced;
    bus_smp_t          smp;
    logic              rd_adv;
    logic [COL_W-1:0]  col;
    logic [PAGE_W-1:0] page;
    logic              bus_oe;
    logic [DATA_W-1:0] rd_byte;

    assign raw = {bus_en, rw_sel, dc_sel, strobe, bus_io};

    lcd_host_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    assign smp = bus_smp_t'(synced);

    lcd_host_route u_route (
        .clk(clk), .rst_n(rst_n), .smp(smp),
        .wr_pulse(ram_we), .rd_adv(rd_adv), .wdata(ram_wdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
    );

    lcd_host_addr #(.COLS(COLS), .PAGES(PAGES)) u_addr (
        .clk(clk), .rst_n(rst_n), .adv(ram_we | rd_adv),
        .col(col), .page(page)
    );

    assign ram_addr = {page, col};

    // Select read source and gate the bus driver on the raw pins.
    assign rd_byte = dc_sel ? ram_rdata : DATA_W'(page);
    assign bus_oe  = rst_n & bus_en & rw_sel & strobe;
    assign bus_io  = bus_oe ? rd_byte : {DATA_W{1'bz}};
endmodule

// File: rtl/lcd_host_port_chk.sv
// Temporal checks on the host port outputs, bound into every instance.
module lcd_host_port_chk #(
    parameter int COLS  = 120,
    parameter int PAGES = 5,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int ADDR_W = COL_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_we,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] ram_addr
);
    logic [COL_W-1:0]  col;
    logic [PAGE_W-1:0] page;
    assign col  = ram_addr[COL_W-1:0];
    assign page = ram_addr[ADDR_W-1:COL_W];

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R1
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R2
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col < COL_W'(COLS)); // R7
    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        page < PAGE_W'(PAGES)); // R7
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && col != COL_W'(COLS-1)) |=> (col == COL_W'($past(col) + 1'b1)) && $stable(page)); // R7
    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && col == COL_W'(COLS-1)) |=> (col == '0)); // R7
endmodule

bind lcd_host_port lcd_host_port_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we),
    .cmd_valid(cmd_valid), .ram_addr(ram_addr)
);

// File: tb/lcd_host_port_test.sv
`timescale 1ns/1ps
module lcd_host_port_test;
    localparam int COLS = 120;
    localparam int PAGES = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, strobe = 1'b0, rw_sel = 1'b0, dc_sel = 1'b0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_data = 8'h00;
    wire  [7:0] bus;
    logic [9:0] ram_addr;
    logic [7:0] ram_wdata, ram_rdata, cmd_byte;
    logic       ram_we, cmd_valid;

    int errs = 0, checks = 0;
    int m_col = 0, m_page = 0;

    always #10 clk = ~clk;

    assign bus = tb_drv ? tb_data : 8'hzz;
    for (genvar g = 0; g < 8; g++) begin : g_pu
        pullup (bus[g]);
    end
    assign ram_rdata = ram_addr[7:0] ^ 8'h5A;

    lcd_host_port uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .strobe(strobe),
        .rw_sel(rw_sel), .dc_sel(dc_sel), .bus_io(bus),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_addr();
        return (m_page << 7) | m_col;
    endfunction

    // One host transfer: strobe high for three cycles, then falling edge.
    task automatic xfer(input bit ce, input bit rw, input bit dc, input logic [7:0] d,
                        input bit exp_we, input bit exp_cv);
        logic [7:0] eb;
        @(negedge clk);
        bus_en = ce; rw_sel = rw; dc_sel = dc; tb_data = d; tb_drv = !rw; strobe = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!ram_we && !cmd_valid, "R10", {ram_we, cmd_valid}, 0);
        end
        if (rw) begin
            if (!ce)     eb = 8'hFF;
            else if (dc) eb = 8'(model_addr()) ^ 8'h5A;
            else         eb = 8'(m_page);
            chk(bus === eb, ce ? (dc ? "R5" : "R6") : "R4", bus, eb);
        end
        strobe = 1'b0;
        @(negedge clk);
        chk(!ram_we, "R1", ram_we, 0);
        @(negedge clk);
        chk(ram_we == exp_we, exp_we ? "R1" : "R3", ram_we, exp_we);
        if (exp_we) begin
            chk(ram_addr == 10'(model_addr()), "R1", ram_addr, model_addr());
            chk(ram_wdata == d, "R1", ram_wdata, d);
        end
        if (ce && dc) begin
            if (m_col == COLS-1) begin
                m_col = 0;
                m_page = (m_page == PAGES-1) ? 0 : m_page + 1;
            end else m_col++;
        end
        @(negedge clk);
        chk(!ram_we, "R1", ram_we, 0);
        chk(cmd_valid == exp_cv, exp_cv ? "R2" : "R3", cmd_valid, exp_cv);
        if (exp_cv) chk(cmd_byte == d, "R2", cmd_byte, d);
        chk(ram_addr == 10'(model_addr()), dc ? "R7" : "R9", ram_addr, model_addr());
        @(negedge clk);
        chk(!cmd_valid, "R2", cmd_valid, 0);
        tb_drv = 1'b0; bus_en = 1'b0;
    endtask

    // {ce, rw, dc, data, exp_we, exp_cv}
    localparam logic [12:0] VEC [10] = '{
        {1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'hAE, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1},
        {1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(ram_addr == 0 && !ram_we && !cmd_valid, "R8", ram_addr, 0);
        bus_en = 1'b1; rw_sel = 1'b1; strobe = 1'b1;
        #1 chk(bus === 8'hFF, "R8", bus, 8'hFF);
        bus_en = 1'b0; rw_sel = 1'b0; strobe = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        for (int v = 0; v < 10; v++)
            xfer(VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9:2], VEC[v][1], VEC[v][0]);

        // R4: enabled read select but strobe low keeps bus released
        @(negedge clk); bus_en = 1'b1; rw_sel = 1'b1; dc_sel = 1'b1;
        @(negedge clk); chk(bus === 8'hFF, "R4", bus, 8'hFF);
        bus_en = 1'b0;

        // R7: walk every column and page until the address wraps to 0
        while (!(m_page == 0 && m_col == 0))
            xfer(1'b1, 1'b0, 1'b1, 8'(m_col), 1'b1, 1'b0);
        chk(ram_addr == 0, "R7", ram_addr, 0);

        // R8: reset mid-operation returns the address to zero
        xfer(1'b1, 1'b0, 1'b1, 8'h77, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(ram_addr == 0 && !ram_we && !cmd_valid, "R8", ram_addr, 0);
        rst_n = 1'b1; m_col = 0; m_page = 0;
        xfer(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule